// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces data addresses for a processor's load and store path. It holds four independent register sets. Each set has an index, a modify value, a base and a length. On each accepted request, the block puts the selected set's current index on the address output. On the next clock edge it post-modifies that index. The step can be the set's modify value, added or subtracted. It can also be a fixed access-size step of 1, 2 or 4 bytes in either direction, or the modify value added with a bit-reversed carry chain. The bit-reversed form produces the reordered address sequences that radix-2 transforms need.

When a set's length is nonzero, the set describes a circular buffer that starts at its base and is length bytes long. A modify or step update that would leave that window is folded back by one length, so a stream of accesses wraps around the buffer. A length of zero turns the set into plain linear pointer arithmetic.

Software or a sequencer loads the registers through a simple write port and can read any of them back. Requests come in on a valid-qualified port that names the set, the operation, the direction and the access size. There is no ready signal: the block accepts one request every cycle with no back-pressure. `addr_valid` follows `req_valid` in the same cycle.

Top module: `circ_agen`

## Requirements
- R1: After reset, every index, modify, base and length register of all sets reads as zero.
- R2: A write with `wr_en` high stores `wr_data` into the register selected by `wr_kind` of set `wr_set`, where `wr_kind` 0 is index, 1 is modify, 2 is base and 3 is length. The value appears on `rd_data` for a matching `rd_kind`/`rd_set` after that clock edge.
- R3: With `req_valid` high, `addr` equals the selected set's index before the update and `addr_valid` is high in the same cycle. The post-modified index takes effect on the next clock edge.
- R4: Operation code 1 (modify) adds the set's modify value to the index, or subtracts it when `req_dec` is 1. A modify value with its top bit set acts as a negative step.
- R5: Operation code 2 (step) adds or subtracts (per `req_dec`) a fixed access size: 1 for `req_size` 0, 2 for `req_size` 1, and 4 for `req_size` 2 or 3.
- R6: With length zero, modify and step updates are plain two's complement arithmetic modulo 2^AW, with no wrapping to the buffer.
- R7: With nonzero length, an index in [base, base+length) and a step no larger than length, an updated index at or above base+length has length subtracted from it, and one below base has length added to it. The result stays in [base, base+length).
- R8: Operation code 3 (bit-reversed) adds the modify value to the index with the carry running from the most significant bit toward the least significant bit. It ignores `req_dec` and the length.
- R9: Operation code 0, or `req_valid` low, leaves every index unchanged.
- R10: Writing a base or length register leaves the index of that set unchanged.
- R11: A request updates only the index of its own set. When an index write and an update hit the same set in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 base, 3 length |
| wr_set | input | SW | Register set written |
| wr_data | input | AW | Write value |
| rd_kind | input | 2 | Register kind read back |
| rd_set | input | SW | Register set read back |
| rd_data | output | AW | Read-back value |
| req_valid | input | 1 | Address request valid |
| req_set | input | SW | Set used by the request |
| req_op | input | 2 | 0 hold, 1 modify, 2 size step, 3 bit-reversed modify |
| req_dec | input | 1 | 1 to subtract for modify and size step |
| req_size | input | 2 | Access size code: 0 one byte, 1 two, 2 or 3 four |
| addr_valid | output | 1 | Address output valid |
| addr | output | AW | Pre-modify index of the selected set |

## Verification
The bench builds the block with a 16-bit address width and four sets. At that width, wrap-around of linear arithmetic below zero is easy to reach, and a bit-reversed sequence can be predicted by hand: with a modify of 4 it yields 0, 4, 2, 6, 1. The circular cases use a 32-byte buffer at 0x200. They cover landing exactly on the buffer end, falling below the base, a negative modify value, and a base/length rewrite with the index left in place. The bench also drives a same-cycle index write against an update on the same set.

// File: rtl/circ_agen_pkg.sv
package circ_agen_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_MOD  = 2'd1,
    OP_STEP = 2'd2,
    OP_BREV = 2'd3
  } agen_op_e;

  typedef enum logic [1:0] {
    RK_IDX  = 2'd0,
    RK_MOD  = 2'd1,
    RK_BASE = 2'd2,
    RK_LEN  = 2'd3
  } reg_kind_e;
endpackage

// File: rtl/circ_agen_brev_add.sv
module circ_agen_brev_add #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic [AW-1:0] sum
);
  logic [AW-1:0] ra, rb, rs;

  // mirror operands so an ordinary adder carries from MSB toward LSB
  for (genvar g = 0; g < AW; g++) begin : g_mirror
    assign ra[g]  = a[AW-1-g];
    assign rb[g]  = b[AW-1-g];
    assign sum[g] = rs[AW-1-g];
  end

  assign rs = ra + rb;
endmodule

// File: rtl/circ_agen_upd.sv
module circ_agen_upd
  import circ_agen_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] mdf,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  input  agen_op_e      op,
  input  logic          dec,
  input  logic [1:0]    size,
  output logic [AW-1:0] nxt
);
  localparam int EW = AW + 2;

  logic [AW-1:0] step_mag, delta, brev_sum, off;
  logic [EW-1:0] noff, fixed_off;

  circ_agen_brev_add #(.AW(AW)) u_brev (.a(idx), .b(mdf), .sum(brev_sum));

  always_comb begin
    unique case (size)
      2'd0:    step_mag = AW'(1);
      2'd1:    step_mag = AW'(2);
      default: step_mag = AW'(4);
    endcase
  end

  always_comb begin
    if (op == OP_STEP) delta = dec ? (~step_mag + 1'b1) : step_mag;
    else               delta = dec ? (~mdf + 1'b1) : mdf;
  end

  // offset-domain wrap: position inside buffer, then fold by one length
  assign off  = idx - base;
  assign noff = {2'b00, off} + {{2{delta[AW-1]}}, delta};

  always_comb begin
    if (noff[EW-1])                  fixed_off = noff + {2'b00, len};
    else if (noff >= {2'b00, len})   fixed_off = noff - {2'b00, len};
    else                             fixed_off = noff;
  end

  always_comb begin
    unique case (op)
      OP_HOLD: nxt = idx;
      OP_BREV: nxt = brev_sum;
      default: nxt = (len == '0) ? (idx + delta) : (base + fixed_off[AW-1:0]);
    endcase
  end

  logic [AW-1:0] delta_abs;
  logic          wrap_chk_en;
  assign delta_abs   = delta[AW-1] ? (~delta + 1'b1) : delta;
  assign wrap_chk_en = (len != '0) && (op == OP_MOD || op == OP_STEP) &&
                       (off < len) && (delta_abs <= len);

  // R7
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_chk_en |-> ((nxt - base) < len));

  // R6
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len == '0 && op == OP_STEP && !dec && size == 2'd2) |-> (nxt - idx == AW'(4)));
endmodule

// File: rtl/circ_agen_regs.sv
module circ_agen_regs
  import circ_agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_kind_e     wr_kind,
  input  logic [SW-1:0] wr_set,
  input  logic [AW-1:0] wr_data,
  input  reg_kind_e     rd_kind,
  input  logic [SW-1:0] rd_set,
  output logic [AW-1:0] rd_data,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_set,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] sel_idx,
  output logic [AW-1:0] sel_mod,
  output logic [AW-1:0] sel_base,
  output logic [AW-1:0] sel_len
);
  logic [NSETS-1:0][AW-1:0] idx_q, mod_q, base_q, len_q;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic hit_wr;
    assign hit_wr = wr_en && (wr_set == SW'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[s]  <= '0;
        mod_q[s]  <= '0;
        base_q[s] <= '0;
        len_q[s]  <= '0;
      end else begin
        if (hit_wr && wr_kind == RK_IDX)                 idx_q[s] <= wr_data;
        else if (upd_en && upd_set == SW'(s))            idx_q[s] <= upd_val;
        if (hit_wr && wr_kind == RK_MOD)  mod_q[s]  <= wr_data;
        if (hit_wr && wr_kind == RK_BASE) base_q[s] <= wr_data;
        if (hit_wr && wr_kind == RK_LEN)  len_q[s]  <= wr_data;
      end
    end
  end

  assign sel_idx  = idx_q[upd_set];
  assign sel_mod  = mod_q[upd_set];
  assign sel_base = base_q[upd_set];
  assign sel_len  = len_q[upd_set];

  always_comb begin
    unique case (rd_kind)
      RK_IDX:  rd_data = idx_q[rd_set];
      RK_MOD:  rd_data = mod_q[rd_set];
      RK_BASE: rd_data = base_q[rd_set];
      default: rd_data = len_q[rd_set];
    endcase
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_en) |=> $stable(idx_q));

  // R10
  geom_write_keeps_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_kind == RK_BASE || wr_kind == RK_LEN) && !upd_en) |=> $stable(idx_q));
endmodule

// File: rtl/circ_agen.sv
module circ_agen
  import circ_agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  localparam int SW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_set,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [SW-1:0] rd_set,
  output logic [AW-1:0] rd_data,
  input  logic          req_valid,
  input  logic [SW-1:0] req_set,
  input  logic [1:0]    req_op,
  input  logic          req_dec,
  input  logic [1:0]    req_size,
  output logic          addr_valid,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] cur_idx, cur_mod, cur_base, cur_len, nxt_idx;
  logic          upd_en;

  assign upd_en = req_valid && (agen_op_e'(req_op) != OP_HOLD);

  circ_agen_regs #(.AW(AW), .NSETS(NSETS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_kind  (reg_kind_e'(wr_kind)),
    .wr_set   (wr_set),
    .wr_data  (wr_data),
    .rd_kind  (reg_kind_e'(rd_kind)),
    .rd_set   (rd_set),
    .rd_data  (rd_data),
    .upd_en   (upd_en),
    .upd_set  (req_set),
    .upd_val  (nxt_idx),
    .sel_idx  (cur_idx),
    .sel_mod  (cur_mod),
    .sel_base (cur_base),
    .sel_len  (cur_len)
  );

  circ_agen_upd #(.AW(AW)) u_upd (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (cur_idx),
    .mdf   (cur_mod),
    .base  (cur_base),
    .len   (cur_len),
    .op    (agen_op_e'(req_op)),
    .dec   (req_dec),
    .size  (req_size),
    .nxt   (nxt_idx)
  );

  assign addr_valid = req_valid;
  assign addr       = cur_idx;

  // R3
  addr_follows_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wr_en && $past(req_valid) && req_set == $past(req_set) &&
     $past(rst_n) && !$past(wr_en)) |-> (addr == $past(nxt_idx)));
endmodule

// File: tb/circ_agen_bench.sv
module circ_agen_bench;
  localparam int AW = 16;
  localparam int NS = 4;
  localparam int SW = 2;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [1:0]    wr_kind = 0;
  logic [SW-1:0] wr_set = 0;
  logic [AW-1:0] wr_data = 0;
  logic [1:0]    rd_kind = 0;
  logic [SW-1:0] rd_set = 0;
  logic [AW-1:0] rd_data;
  logic          req_valid = 0;
  logic [SW-1:0] req_set = 0;
  logic [1:0]    req_op = 0;
  logic          req_dec = 0;
  logic [1:0]    req_size = 0;
  logic          addr_valid;
  logic [AW-1:0] addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  circ_agen #(.AW(AW), .NSETS(NS)) u_circ_agen (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int k, input int s, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = 2'(k); wr_set = SW'(s); wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input int k, input int s, output logic [AW-1:0] v);
    rd_kind = 2'(k); rd_set = SW'(s);
    #1 v = rd_data;
  endtask

  task automatic req(input int s, input int op, input bit dec, input int sz,
                     output logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_set = SW'(s); req_op = 2'(op); req_dec = dec; req_size = 2'(sz);
    #1 a = addr;
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic t_reset();
    logic [AW-1:0] v;
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < NS; s++) begin
        rd(k, s, v);
        check("R1 reset zero", v, '0);
      end
  endtask

  task automatic t_write_read();
    logic [AW-1:0] v;
    wr(1, 2, 16'h1234); wr(2, 2, 16'h0300); wr(3, 2, 16'h0040); wr(0, 2, 16'h0310);
    rd(1, 2, v); check("R2 modify readback", v, 16'h1234);
    rd(2, 2, v); check("R2 base readback", v, 16'h0300);
    rd(3, 2, v); check("R2 length readback", v, 16'h0040);
    rd(0, 2, v); check("R2 index readback", v, 16'h0310);
    rd(0, 1, v); check("R2 other set untouched", v, 16'h0000);
  endtask

  task automatic t_modify_linear();
    logic [AW-1:0] a, v;
    wr(0, 0, 16'h0100); wr(1, 0, 16'h0010);
    @(negedge clk);
    req_valid = 1; req_set = 0; req_op = 1; req_dec = 0;
    #1 total++;
    if (addr_valid !== 1'b1) begin bad++; $display("FAIL R3 addr_valid actual=%b expected=1", addr_valid); end
    @(posedge clk); #1 req_valid = 0;
    rd(0, 0, v); check("R3 R4 index after add", v, 16'h0110);
    req(0, 1, 1, 0, a); check("R3 pre-modify address", a, 16'h0110);
    rd(0, 0, v); check("R4 index after subtract", v, 16'h0100);
    wr(1, 0, 16'hFFF0);
    req(0, 1, 0, 0, a); rd(0, 0, v); check("R4 negative modify", v, 16'h00F0);
  endtask

  task automatic t_step();
    logic [AW-1:0] a, v;
    wr(0, 1, 16'h0040);
    req(1, 2, 0, 2, a); check("R3 step addr", a, 16'h0040);
    rd(0, 1, v); check("R5 +4", v, 16'h0044);
    req(1, 2, 1, 1, a); rd(0, 1, v); check("R5 -2", v, 16'h0042);
    req(1, 2, 0, 0, a); rd(0, 1, v); check("R5 +1", v, 16'h0043);
    req(1, 2, 1, 3, a); rd(0, 1, v); check("R5 size3 -4", v, 16'h003F);
    wr(0, 1, 16'h0002);
    req(1, 2, 1, 2, a); rd(0, 1, v); check("R6 linear underflow", v, 16'hFFFE);
  endtask

  task automatic t_circular();
    logic [AW-1:0] a, v;
    wr(2, 0, 16'h0200); wr(3, 0, 16'h0020); wr(1, 0, 16'h000C); wr(0, 0, 16'h0218);
    req(0, 1, 0, 0, a); rd(0, 0, v); check("R7 wrap above end", v, 16'h0204);
    req(0, 1, 1, 0, a); rd(0, 0, v); check("R7 wrap below base", v, 16'h0218);
    wr(0, 0, 16'h0214);
    req(0, 1, 0, 0, a); rd(0, 0, v); check("R7 exactly end folds to base", v, 16'h0200);
    wr(1, 0, 16'hFFF4);
    req(0, 1, 0, 0, a); rd(0, 0, v); check("R7 negative modify wraps", v, 16'h0214);
    req(0, 2, 0, 2, a); rd(0, 0, v); check("R7 step inside window", v, 16'h0218);
  endtask

  task automatic t_brev();
    logic [AW-1:0] a, v;
    logic [AW-1:0] seq [5] = '{16'h0000, 16'h0004, 16'h0002, 16'h0006, 16'h0001};
    wr(2, 3, 16'h0100); wr(3, 3, 16'h0008); wr(1, 3, 16'h0004); wr(0, 3, 16'h0000);
    for (int i = 0; i < 4; i++) begin
      req(3, 3, (i % 2) == 1, 0, a);
      check("R8 bit-reversed address", a, seq[i]);
    end
    rd(0, 3, v); check("R8 bit-reversed final index", v, seq[4]);
  endtask

  task automatic t_idle_and_geometry();
    logic [AW-1:0] a, v;
    wr(0, 2, 16'h0310);
    req(2, 0, 0, 2, a); rd(0, 2, v); check("R9 hold op", v, 16'h0310);
    @(negedge clk); req_valid = 0; req_set = 2; req_op = 1;
    @(posedge clk); #1 rd(0, 2, v); check("R9 valid low", v, 16'h0310);
    req_op = 0;
    wr(2, 2, 16'h0000); wr(3, 2, 16'h0008);
    rd(0, 2, v); check("R10 base/length write keeps index", v, 16'h0310);
  endtask

  task automatic t_collision();
    logic [AW-1:0] v;
    wr(0, 1, 16'h0700);
    @(negedge clk);
    wr_en = 1; wr_kind = 0; wr_set = 0; wr_data = 16'h0555;
    req_valid = 1; req_set = 0; req_op = 2; req_dec = 0; req_size = 2;
    @(posedge clk); #1 wr_en = 0; req_valid = 0;
    rd(0, 0, v); check("R11 write beats update", v, 16'h0555);
    rd(0, 1, v); check("R11 other set untouched", v, 16'h0700);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_write_read();
    t_modify_linear();
    t_step();
    t_circular();
    t_brev();
    t_idle_and_geometry();
    t_collision();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule